// File: doc/BRIEF.md
# Slot-Indexed ADC Sample Buffer

This block takes the stream of converted samples that an ADC sequencer produces and writes each one into a small on-chip RAM. The RAM entry is chosen by the sample's position in the conversion sequence, not by its channel number. A channel that is converted several times in one sequence therefore fills several entries. Each entry keeps the 12-bit result together with the channel number that produced it.

A block of samples is complete when a sample flagged as the last of the sequence is stored, or when the last configured slot is filled. Completion sets a sticky status bit. The interrupt output is that bit gated by a run-time enable bit. Software can either take the interrupt or, with the interrupt masked, poll the status bit. It reads the stored samples through a simple word-addressed register port with one cycle of read latency. New samples overwrite older contents. Everything runs on one clock.

Top module: `slot_sample_buffer`

## Requirements
- R1: After a synchronous active-low reset, irq is 0, the enable and status bits read 0, every slot reads 0 and the next sample goes to slot 0.
- R2: Each cycle with in_valid high stores {in_channel, in_data} into the current slot and advances the slot pointer by one. For example, the channel sequence 1,2,1,3,1,4 puts channel 1 in slots 0, 2 and 4.
- R3: A sample with in_sop high is stored in slot 0 whatever the pointer holds, and the pointer then moves to slot 1 (or back to 0 if that sample also ends the block).
- R4: A sample with in_eop high completes the block, and the pointer returns to slot 0.
- R5: Storing into slot SLOTS-1 completes the block and returns the pointer to slot 0, with no in_eop needed.
- R6: The status bit (address 0x41, bit 0) reads 1 from the clock edge that stores the completing sample and stays 1 until software clears it.
- R7: Writing 1 to status bit 0 clears it; writing 0 leaves it unchanged. If a block completes in the same cycle as a clearing write, the bit stays set.
- R8: The enable bit (address 0x40, bit 0) can be written and read at any time, and irq is 1 exactly when both the status and enable bits are 1.
- R9: A read strobe at address A gives reg_rdata on the next clock edge. Slot addresses 0..SLOTS-1 return channel in bits 20:16 and sample data in bits 11:0, with all other bits 0. Addresses 0x40 and 0x41 return the enable and status bits in bit 0. Any other address returns 0.
- R10: A cycle with in_valid low writes no slot and leaves the pointer unchanged. A later block overwrites the earlier contents of the slots it reaches.
- R11: A read of a slot in the same cycle that a sample is stored into that slot returns the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on the stream this cycle |
| in_channel | input | 5 | Channel number of the sample |
| in_data | input | 12 | Converted sample value |
| in_sop | input | 1 | Sample is the first of a sequence |
| in_eop | input | 1 | Sample is the last of a sequence |
| reg_addr | input | 7 | Word address of the register port |
| reg_read | input | 1 | Read strobe |
| reg_write | input | 1 | Write strobe |
| reg_wbit | input | 1 | Write data; only bit 0 of the control registers is writable |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Block-complete interrupt, status AND enable |

## Verification
A stored sample can be read back on the first read strobe after the edge that stored it, and that read returns data one edge after its strobe. The status bit and irq change on the same edge that stores the completing sample. The bench drives every input on the falling edge and samples outputs on the following falling edge, so every result is checked exactly one rising edge after its cause. Same-edge collisions are checked at that edge: a read and a store to one slot, and a clearing write against a completion.

// File: rtl/ssb_pkg.sv
// Package: shared widths, register addresses and the slot entry type for the
// slot-indexed sample buffer. Assumes a word-addressed register port.
package ssb_pkg;
    localparam int DATA_W  = 12;
    localparam int CH_W    = 5;
    localparam int ADDR_W  = 7;
    localparam int RDATA_W = 32;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 7'h40;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 7'h41;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } slot_entry_t;

    localparam int ENTRY_W = CH_W + DATA_W;
endpackage

// File: rtl/ssb_slot_ptr.sv
// Slot pointer: picks the slot for each incoming sample and detects block
// completion. Assumes SLOTS >= 1 and that in_sop/in_eop are only meaningful
// while in_valid is high.
module ssb_slot_ptr #(
    parameter int SLOTS = 16,
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_slot,
    output logic             blk_done,
    output logic [PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);

    logic last_slot;

    // Slot choice and completion decode for the current sample.
    always_comb begin
        wr_en     = in_valid;
        wr_slot   = in_sop ? '0 : ptr_q;
        last_slot = in_eop || (wr_slot == LAST_SLOT);
        blk_done  = in_valid && last_slot;
    end

    // Pointer update: wrap on completion, step otherwise, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (in_valid) begin
            if (last_slot) ptr_q <= '0;
            else           ptr_q <= wr_slot + PTR_W'(1);
        end
    end
endmodule

// File: rtl/ssb_slot_ram.sv
// Slot RAM: one write port from the stream, one registered read port for the
// register interface. A read and a write to the same slot in one cycle return
// the old contents. Assumes DEPTH is small enough for a reset loop.
module ssb_slot_ram
    import ssb_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  slot_entry_t       wentry,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output slot_entry_t       rentry_q
);
    slot_entry_t mem [DEPTH];

    // Storage write, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wentry;
        end
    end

    // Registered read port; holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  rentry_q <= '0;
        else if (re) rentry_q <= mem[raddr];
    end
endmodule

// File: rtl/ssb_regs.sv
// Control registers: run-time interrupt enable and sticky block-complete
// status with write-one-to-clear. Completion wins over a clearing write in the
// same cycle. Assumes one-bit control fields at bit 0.
module ssb_regs
    import ssb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_read,
    input  logic               reg_write,
    input  logic               reg_wbit,
    input  logic               blk_done,
    output logic               enable_q,
    output logic               status_q,
    output logic [RDATA_W-1:0] ctrl_rdata_q,
    output logic               irq
);
    logic wr_enable;
    logic clr_status;

    // Write strobes for each control register.
    always_comb begin
        wr_enable  = reg_write && (reg_addr == ADDR_ENABLE);
        clr_status = reg_write && (reg_addr == ADDR_STATUS) && reg_wbit;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= 1'b0;
        else if (wr_enable) enable_q <= reg_wbit;
    end

    // Sticky status: set on completion, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (blk_done)   status_q <= 1'b1;
        else if (clr_status) status_q <= 1'b0;
    end

    // Registered read of the control registers; unmapped reads give zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rdata_q <= '0;
        end else if (reg_read) begin
            case (reg_addr)
                ADDR_ENABLE: ctrl_rdata_q <= {{(RDATA_W-1){1'b0}}, enable_q};
                ADDR_STATUS: ctrl_rdata_q <= {{(RDATA_W-1){1'b0}}, status_q};
                default:     ctrl_rdata_q <= '0;
            endcase
        end
    end

    // Interrupt output: status gated by enable.
    assign irq = status_q && enable_q;
endmodule

// File: rtl/slot_sample_buffer.sv
// Top: slot-indexed ADC sample buffer. Stores each streamed sample by its
// sequence slot, flags block completion, and serves register reads with one
// cycle of latency. Assumes 1 <= SLOTS <= 64 and a single clock.
module slot_sample_buffer
    import ssb_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CH_W-1:0]      in_channel,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_read,
    input  logic                 reg_write,
    input  logic                 reg_wbit,
    output logic [RDATA_W-1:0]   reg_rdata,
    output logic                 irq
);
    localparam int PTR_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int HI_PAD  = RDATA_W - 16 - CH_W;
    localparam int MID_PAD = 16 - DATA_W;

    logic               wr_en;
    logic [PTR_W-1:0]   wr_slot;
    logic               blk_done;
    logic [PTR_W-1:0]   wr_ptr;
    logic               enable_q;
    logic               status_q;
    logic [RDATA_W-1:0] ctrl_rdata_q;
    logic               addr_is_slot;
    logic               rd_sel_slot_q;
    slot_entry_t        wentry;
    slot_entry_t        rentry_q;

    // Slot address decode and write entry packing.
    always_comb begin
        addr_is_slot = (reg_addr < ADDR_W'(SLOTS));
        wentry.ch    = in_channel;
        wentry.data  = in_data;
    end

    ssb_slot_ptr #(
        .SLOTS (SLOTS),
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .blk_done (blk_done),
        .ptr_q    (wr_ptr)
    );

    ssb_slot_ram #(
        .PTR_W (PTR_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (wr_slot),
        .wentry   (wentry),
        .re       (reg_read && addr_is_slot),
        .raddr    (reg_addr[PTR_W-1:0]),
        .rentry_q (rentry_q)
    );

    ssb_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_read     (reg_read),
        .reg_write    (reg_write),
        .reg_wbit     (reg_wbit),
        .blk_done     (blk_done),
        .enable_q     (enable_q),
        .status_q     (status_q),
        .ctrl_rdata_q (ctrl_rdata_q),
        .irq          (irq)
    );

    // Remember which source the last read targeted.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_sel_slot_q <= 1'b0;
        else if (reg_read) rd_sel_slot_q <= addr_is_slot;
    end

    // Read data steering: slot entry layout or control word.
    always_comb begin
        if (rd_sel_slot_q)
            reg_rdata = {{HI_PAD{1'b0}}, rentry_q.ch, {MID_PAD{1'b0}}, rentry_q.data};
        else
            reg_rdata = ctrl_rdata_q;
    end
endmodule

// File: rtl/ssb_checker.sv
// Checker: temporal properties of the slot pointer, status and interrupt,
// bound into every slot_sample_buffer instance.
module ssb_checker
    import ssb_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int PTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic              in_eop,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_write,
    input logic              reg_wbit,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              status_q,
    input logic              enable_q,
    input logic              irq
);
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_ptr) < SLOTS);  // R2
    AST_SOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !in_eop && SLOTS > 1) |=> (wr_ptr == PTR_W'(1)));  // R3
    AST_EOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> (wr_ptr == '0));  // R4
    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && wr_ptr == PTR_W'(SLOTS - 1)) |=> (wr_ptr == '0));  // R5
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> status_q);  // R6
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(reg_write && reg_addr == ADDR_STATUS && reg_wbit)) |=> status_q);  // R6
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_write && reg_addr == ADDR_STATUS && reg_wbit && !in_valid) |=> !status_q);  // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |-> !irq);  // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_ptr));  // R10
endmodule

bind slot_sample_buffer ssb_checker #(
    .SLOTS (SLOTS),
    .PTR_W (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .reg_addr  (reg_addr),
    .reg_write (reg_write),
    .reg_wbit  (reg_wbit),
    .wr_ptr    (wr_ptr),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .irq       (irq)
);

// File: tb/slot_sample_buffer_test.sv
// Bench: table-driven stream checks, then directed reset and corner tests.
module slot_sample_buffer_test;
    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_channel = '0;
    logic [11:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_read = 1'b0;
    logic        reg_write = 1'b0;
    logic        reg_wbit = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    slot_sample_buffer #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_channel(in_channel),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .reg_addr(reg_addr),
        .reg_read(reg_read), .reg_write(reg_write), .reg_wbit(reg_wbit),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Stimulus table: ch[23:19] data[18:7] sop[6] eop[5] done[4] slot[3:0]
    localparam logic [23:0] VEC [0:9] = '{
        {5'd1, 12'h101, 1'b1, 1'b0, 1'b0, 4'd0},
        {5'd2, 12'h202, 1'b0, 1'b0, 1'b0, 4'd1},
        {5'd1, 12'h103, 1'b0, 1'b0, 1'b0, 4'd2},
        {5'd3, 12'h304, 1'b0, 1'b0, 1'b0, 4'd3},
        {5'd1, 12'h105, 1'b0, 1'b0, 1'b0, 4'd4},
        {5'd4, 12'h406, 1'b0, 1'b1, 1'b1, 4'd5},
        {5'd7, 12'h7AA, 1'b0, 1'b0, 1'b0, 4'd0},
        {5'd6, 12'h655, 1'b0, 1'b0, 1'b0, 4'd1},
        {5'd5, 12'h5F0, 1'b1, 1'b0, 1'b0, 4'd0},
        {5'd9, 12'h0F1, 1'b0, 1'b0, 1'b0, 4'd1}
    };

    function automatic logic [31:0] fmt(input logic [4:0] ch, input logic [11:0] d);
        return {11'b0, ch, 4'b0, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] ch, input logic [11:0] d, input logic sop, input logic eop);
        in_valid = 1'b1; in_channel = ch; in_data = d; in_sop = sop; in_eop = eop;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        reg_read = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_read = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [6:0] a, input logic b);
        reg_write = 1'b1; reg_addr = a; reg_wbit = b;
        @(negedge clk);
        reg_write = 1'b0; reg_wbit = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        rd(7'h40, v); chk("R1 enable", v, 32'd0);
        rd(7'h41, v); chk("R1 status", v, 32'd0);
        rd(7'd3, v);  chk("R1 slot3", v, 32'd0);

        // R2 R3 R4 R6 R9: table of stream samples
        for (int i = 0; i < 10; i++) begin
            send(VEC[i][23:19], VEC[i][18:7], VEC[i][6], VEC[i][5]);
            rd(7'(VEC[i][3:0]), v);
            chk("R2 slot contents", v, fmt(VEC[i][23:19], VEC[i][18:7]));
            rd(7'h41, v);
            chk("R6 status after sample", v, {31'b0, VEC[i][4]});
            if (VEC[i][4]) wr(7'h41, 1'b1);
        end
        // R2: channel 1 still sits in slots 2 and 4 of the first sequence
        rd(7'd2, v); chk("R2 ch1 slot2", v, fmt(5'd1, 12'h103));
        rd(7'd4, v); chk("R2 ch1 slot4", v, fmt(5'd1, 12'h105));

        // R5: fill all slots without eop; last slot completes and wraps
        for (int i = 0; i < SLOTS; i++) send(5'd2, 12'(12'h800 + i), (i == 0), 1'b0);
        rd(7'h41, v); chk("R5 status on last slot", v, 32'd1);
        chk("R8 irq masked", {31'b0, irq}, 32'd0);
        send(5'd11, 12'hABC, 1'b0, 1'b0);
        rd(7'd0, v); chk("R5 wrapped to slot 0", v, fmt(5'd11, 12'hABC));
        rd(7'd7, v); chk("R10 overwritten slot7", v, fmt(5'd2, 12'h807));

        // R8: enable at run time
        wr(7'h40, 1'b1);
        chk("R8 irq enabled", {31'b0, irq}, 32'd1);
        rd(7'h40, v); chk("R8 enable readback", v, 32'd1);

        // R7: write 0 keeps status, write 1 clears it
        wr(7'h41, 1'b0);
        rd(7'h41, v); chk("R7 write0 no effect", v, 32'd1);
        wr(7'h41, 1'b1);
        rd(7'h41, v); chk("R7 write1 clears", v, 32'd0);
        chk("R8 irq after clear", {31'b0, irq}, 32'd0);

        // R7: completion and clearing write in one cycle, set wins
        reg_write = 1'b1; reg_addr = 7'h41; reg_wbit = 1'b1;
        send(5'd12, 12'h3C3, 1'b0, 1'b1);
        reg_write = 1'b0; reg_wbit = 1'b0;
        chk("R7 set wins irq", {31'b0, irq}, 32'd1);
        rd(7'd1, v); chk("R4 eop sample slot1", v, fmt(5'd12, 12'h3C3));

        // R10: idle cycle with data on the bus writes nothing
        in_valid = 1'b0; in_channel = 5'd3; in_data = 12'hDDD; in_sop = 1'b1;
        @(negedge clk);
        in_sop = 1'b0;
        rd(7'd0, v); chk("R10 idle no write", v, fmt(5'd11, 12'hABC));
        send(5'd13, 12'h111, 1'b0, 1'b0);
        rd(7'd0, v); chk("R10 pointer held", v, fmt(5'd13, 12'h111));

        // R11: read and store to slot 0 in the same cycle
        reg_read = 1'b1; reg_addr = 7'd0;
        send(5'd14, 12'h222, 1'b1, 1'b0);
        reg_read = 1'b0;
        chk("R11 old contents", reg_rdata, fmt(5'd13, 12'h111));
        rd(7'd0, v); chk("R11 new contents", v, fmt(5'd14, 12'h222));

        // R9: unmapped and out-of-range addresses read zero
        rd(7'h50, v); chk("R9 unmapped", v, 32'd0);
        rd(7'd10, v); chk("R9 slot beyond depth", v, 32'd0);

        finish_run();
    end
endmodule